// File: doc/BRIEF.md
# I2C-Controlled Eight-Pin GPIO Expander

This block is an I2C target that gives a host eight general-purpose pins. Each pin has its own direction bit, output level bit and read-inversion bit. The pin levels can be read back through the bus. The block runs on a fast system clock and oversamples the SCL and SDA lines. It detects Start and Stop, shifts bytes in and out MSB first, and pulls SDA low through an open-drain enable to acknowledge.

A host transaction opens with the device address. The upper four address bits come from a parameter, and the lower three come from strap inputs that are latched at Start. The next byte is a command byte that selects one of four byte-wide registers. Data bytes after it are written to that register. After a repeated Start, or in a later read transaction, the same register is returned, byte after byte, until the host answers with NACK.

An active-low interrupt tells the host that a pin configured as an input no longer matches the value it saw when it last read the input register.

Top module: `gpx_expander`

## Requirements
- R1: After reset the output register is 0xFF, the polarity register is 0x00 and the configuration register is 0xFF. Every pin is therefore undriven (`portOe` = 0), `intN` is high and `sdaLow` is 0.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Bits are sampled on SCL rising edges, and bus activity before a Start is ignored (no acknowledge).
- R3: The 7-bit address is {ADDR_HI, addrStrap}, sent MSB first and followed by the read bit (1 = read). On a match the block holds SDA low through the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next Start.
- R4: The command byte is acknowledged, and its bits [1:0] select the register: 0 input, 1 output, 2 polarity, 3 configuration.
- R5: Every write data byte is acknowledged and stored in the selected register; repeated bytes go to the same register. Writes to the input register are acknowledged but have no effect.
- R6: A pin whose configuration bit is 1 is an input and is not driven. A pin whose bit is 0 drives `portOut` equal to its output register bit. `portOe` changes only after a configuration write.
- R7: Reading register 0 returns the pin levels XOR the polarity register. Registers 1 to 3 read back as stored. Data goes out MSB first.
- R8: A read repeats the selected register for as long as the host acknowledges. After a host NACK the block releases SDA.
- R9: `intN` is low while any input pin differs from a snapshot. The snapshot resets to 0xFF and takes the pin levels each time register 0 is loaded for a read. `intN` returns high when the pins match again. Pins configured as outputs never cause an interrupt.
- R10: The block changes `sdaLow` only while SCL is low.
- R11: The strap value latched at Start applies to the whole transaction, even if `addrStrap` changes afterwards.
- R12: A repeated Start without a Stop begins a new address phase and keeps the register pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND bus value) |
| sdaLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| addrStrap | input | 3 | Low three device address bits |
| portIn | input | 8 | Pin levels seen at the pads |
| portOut | output | 8 | Level driven on output pins |
| portOe | output | 8 | Per-pin drive enable, 1 = driving |
| intN | output | 1 | Active-low input-change interrupt |

## Verification
The bench sends an address before any Start. A design that fails to gate on Start would acknowledge it. It also checks that a mismatched address leaves registers untouched. A write to the input register must be acknowledged yet change nothing, and a design that decodes the pointer loosely would corrupt the other registers. The bench toggles a pin configured as an output, and a design that left out the direction mask from the interrupt would pull `intN` low. It also changes the straps right after Start and issues a repeated Start, which catch designs that sample the strap late or reset the pointer at Start.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 3;
  localparam int HI_W    = ADDR_W - STRAP_W;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    SEL_INPUT    = 2'd0,
    SEL_OUTPUT   = 2'd1,
    SEL_POLARITY = 2'd2,
    SEL_CONFIG   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrEn;
    regSel_e           wrSel;
    logic [BYTE_W-1:0] wrData;
    logic              rdSnap;
    regSel_e           rdSel;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK
  } busState_e;

  typedef enum logic [1:0] {
    BK_ADDR, BK_CMD, BK_DATA
  } byteKind_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] flop;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop <= RST_VAL;
        else        flop <= din;
      end
      assign dout = flop;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0100,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [BYTE_W-1:0]  rdData,
  output logic               sdaLow,
  output ctrlStrobe_t        strobe,
  output logic               sclLevel,
  output logic               busIdle
);
  logic [1:0] busLevel;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  gpx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_busSync (
    .clk(clk), .rst_n(rst_n), .din({sclIn, sdaIn}), .dout(busLevel)
  );
  assign sclS = busLevel[1];
  assign sdaS = busLevel[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_e          state;
  byteKind_e          kind;
  logic [CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]  rxShift, txShift;
  logic [STRAP_W-1:0] strapLat;
  regSel_e            ptr;
  logic               isRead, masterAck, sdaLowQ;
  logic               wrEnQ, rdSnapQ;
  regSel_e            wrSelQ;
  logic [BYTE_W-1:0]  wrDataQ;
  logic               addrMatch, byteFull;

  assign addrMatch = (rxShift[BYTE_W-1:1] == {ADDR_HI, strapLat});
  assign byteFull  = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= BK_ADDR;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      strapLat  <= '0;
      ptr       <= SEL_INPUT;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sdaLowQ   <= 1'b0;
      wrEnQ     <= 1'b0;
      wrSelQ    <= SEL_INPUT;
      wrDataQ   <= '0;
      rdSnapQ   <= 1'b0;
    end else begin
      wrEnQ   <= 1'b0;
      rdSnapQ <= 1'b0;
      if (startDet) begin
        state    <= ST_RX;
        kind     <= BK_ADDR;
        bitCnt   <= '0;
        sdaLowQ  <= 1'b0;
        strapLat <= addrStrap;
      end else if (stopDet) begin
        state   <= ST_IDLE;
        sdaLowQ <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_RX: begin
            if (sclRise && !byteFull) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaS};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && byteFull) begin
              unique case (kind)
                BK_ADDR: begin
                  if (addrMatch) begin
                    sdaLowQ <= 1'b1;
                    isRead  <= rxShift[0];
                    state   <= ST_RXACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BK_CMD: begin
                  ptr     <= regSel_e'(rxShift[1:0]);
                  sdaLowQ <= 1'b1;
                  state   <= ST_RXACK;
                end
                default: begin
                  wrEnQ   <= 1'b1;
                  wrSelQ  <= ptr;
                  wrDataQ <= rxShift;
                  sdaLowQ <= 1'b1;
                  state   <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (kind == BK_ADDR && isRead) begin
                txShift <= rdData;
                sdaLowQ <= ~rdData[BYTE_W-1];
                rdSnapQ <= (ptr == SEL_INPUT);
                state   <= ST_TX;
              end else begin
                sdaLowQ <= 1'b0;
                state   <= ST_RX;
                kind    <= (kind == BK_ADDR) ? BK_CMD : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (byteFull) begin
                sdaLowQ <= 1'b0;
                state   <= ST_TXACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaLowQ <= ~txShift[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                bitCnt  <= '0;
                txShift <= rdData;
                sdaLowQ <= ~rdData[BYTE_W-1];
                rdSnapQ <= (ptr == SEL_INPUT);
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.wrEn   = wrEnQ;
    strobe.wrSel  = wrSelQ;
    strobe.wrData = wrDataQ;
    strobe.rdSnap = rdSnapQ;
    strobe.rdSel  = ptr;
  end

  assign sdaLow   = sdaLowQ;
  assign sclLevel = sclS;
  assign busIdle  = (state == ST_IDLE);
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] OUT_RST  = 8'hFF,
  parameter logic [BYTE_W-1:0] POL_RST  = 8'h00,
  parameter logic [BYTE_W-1:0] CFG_RST  = 8'hFF,
  parameter logic [BYTE_W-1:0] SNAP_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] portIn,
  output logic [BYTE_W-1:0] portOut,
  output logic [BYTE_W-1:0] portOe,
  output logic              intN,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] pinLevel
);
  logic [BYTE_W-1:0] pinSync, outReg, polReg, cfgReg, snapReg, diffMask;

  gpx_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL({BYTE_W{1'b1}})) u_pinSync (
    .clk(clk), .rst_n(rst_n), .din(portIn), .dout(pinSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg <= OUT_RST;
      polReg <= POL_RST;
      cfgReg <= CFG_RST;
    end else if (strobe.wrEn) begin
      unique case (strobe.wrSel)
        SEL_OUTPUT:   outReg <= strobe.wrData;
        SEL_POLARITY: polReg <= strobe.wrData;
        SEL_CONFIG:   cfgReg <= strobe.wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             snapReg <= SNAP_RST;
    else if (strobe.rdSnap) snapReg <= pinSync;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_INPUT:    rdData = pinSync ^ polReg;
      SEL_OUTPUT:   rdData = outReg;
      SEL_POLARITY: rdData = polReg;
      default:      rdData = cfgReg;
    endcase
  end

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pin
      assign portOe[i]   = ~cfgReg[i];
      assign portOut[i]  = outReg[i];
      assign diffMask[i] = (pinSync[i] ^ snapReg[i]) & cfgReg[i];
    end
  endgenerate

  assign intN     = ~|diffMask;
  assign pinLevel = pinSync;
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0100,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaLow,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [BYTE_W-1:0]  portIn,
  output logic [BYTE_W-1:0]  portOut,
  output logic [BYTE_W-1:0]  portOe,
  output logic               intN
);
  ctrlStrobe_t       strobe;
  logic [BYTE_W-1:0] rdData, pinLevel;
  logic              sclLevel, busIdle;

  gpx_ctrl #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .rdData(rdData), .sdaLow(sdaLow),
    .strobe(strobe), .sclLevel(sclLevel), .busIdle(busIdle)
  );

  gpx_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .portIn(portIn),
    .portOut(portOut), .portOe(portOe), .intN(intN),
    .rdData(rdData), .pinLevel(pinLevel)
  );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
  import gpx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclLevel,
  input logic              sdaLow,
  input logic              busIdle,
  input ctrlStrobe_t       strobe,
  input logic [BYTE_W-1:0] pinLevel,
  input logic [BYTE_W-1:0] portOe,
  input logic [BYTE_W-1:0] portOut,
  input logic              intN
);
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclLevel && $past(sclLevel)) |-> $stable(sdaLow)); // R10

  AST_OE_ONLY_ON_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.wrEn && strobe.wrSel == SEL_CONFIG) |-> $stable(portOe)); // R6

  AST_OUT_ONLY_ON_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.wrEn && strobe.wrSel == SEL_OUTPUT) |-> $stable(portOut)); // R5

  AST_INT_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdSnap |=> (intN || !$stable(pinLevel))); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busIdle |-> !sdaLow); // R3
endmodule

bind gpx_expander gpx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclLevel(sclLevel), .sdaLow(sdaLow),
  .busIdle(busIdle), .strobe(strobe), .pinLevel(pinLevel),
  .portOe(portOe), .portOut(portOut), .intN(intN)
);

// File: tb/gpx_expander_tb.sv
module gpx_expander_tb;
  localparam int Q = 8;
  localparam logic [7:0] WADDR = 8'h46;
  localparam logic [7:0] RADDR = 8'h47;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sda;
  logic sdaLow, intN;
  logic [2:0] strap = 3'b011;
  logic [7:0] pins = 8'hFF;
  logic [7:0] portOut, portOe;
  int errors = 0;
  int checks = 0;
  int glitches = 0;
  logic prevScl = 1'b1;
  logic prevLow = 1'b0;

  always #5 clk = ~clk;
  assign sda = sdaM & ~sdaLow;

  gpx_expander u_dut (
    .clk(clk), .rst_n(rst_n), .sclIn(scl), .sdaIn(sda), .sdaLow(sdaLow),
    .addrStrap(strap), .portIn(pins), .portOut(portOut), .portOe(portOe),
    .intN(intN)
  );

  always @(negedge clk) begin
    prevScl <= scl;
    prevLow <= sdaLow;
    if (rst_n && scl && prevScl && (sdaLow != prevLow)) glitches <= glitches + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC;
    sdaM = 1'b1; waitQ; scl = 1'b1; waitQ; sdaM = 1'b0; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic stopC;
    sdaM = 1'b0; waitQ; scl = 1'b1; waitQ; sdaM = 1'b1; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ; scl = 1'b1; waitQ; waitQ; scl = 1'b0; waitQ;
    end
    sdaM = 1'b1; waitQ; scl = 1'b1; waitQ;
    acked = (sda == 1'b0);
    waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ; scl = 1'b1; waitQ; b[i] = sda; waitQ; scl = 1'b0;
    end
    waitQ; sdaM = ~giveAck; scl = 1'b1; waitQ; waitQ; scl = 1'b0; waitQ; sdaM = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] sel, input logic [7:0] data);
    bit a;
    startC;
    sendByte(WADDR, a); chk(a, "R3 address ack", {7'd0, a}, 8'd1);
    sendByte(sel, a);   chk(a, "R4 command ack", {7'd0, a}, 8'd1);
    sendByte(data, a);  chk(a, "R5 data ack", {7'd0, a}, 8'd1);
    stopC;
  endtask

  task automatic readReg(input logic [7:0] sel, output logic [7:0] val);
    bit a;
    startC;
    sendByte(WADDR, a);
    sendByte(sel, a);
    startC;
    sendByte(RADDR, a); chk(a, "R12 read address ack after repeated start", {7'd0, a}, 8'd1);
    recvByte(1'b0, val);
    stopC;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(portOe == 8'h00, "R1 portOe after reset", portOe, 8'h00);
    chk(intN == 1'b1, "R1 intN after reset", {7'd0, intN}, 8'd1);
    chk(sdaLow == 1'b0, "R1 sda released", {7'd0, sdaLow}, 8'd0);
    readReg(8'd1, v); chk(v == 8'hFF, "R1 output reg reset", v, 8'hFF);
    readReg(8'd2, v); chk(v == 8'h00, "R1 polarity reg reset", v, 8'h00);
    readReg(8'd3, v); chk(v == 8'hFF, "R1 config reg reset", v, 8'hFF);
  endtask

  task automatic t_noStart;
    bit a;
    scl = 1'b0; waitQ;
    sendByte(WADDR, a);
    chk(!a, "R2 no ack without start", {7'd0, a}, 8'd0);
    stopC;
  endtask

  task automatic t_wrongAddr;
    bit a;
    logic [7:0] v;
    startC;
    sendByte(8'h48, a); chk(!a, "R3 mismatched address not acked", {7'd0, a}, 8'd0);
    sendByte(8'h02, a); chk(!a, "R3 ignored after mismatch", {7'd0, a}, 8'd0);
    sendByte(8'h55, a);
    stopC;
    readReg(8'd2, v); chk(v == 8'h00, "R3 registers untouched", v, 8'h00);
  endtask

  task automatic t_direction;
    logic [7:0] v;
    writeReg(8'd1, 8'hA5);
    writeReg(8'd3, 8'hF0);
    chk(portOe == 8'h0F, "R6 drive enables follow config", portOe, 8'h0F);
    chk(portOut[3:0] == 4'h5, "R6 driven levels", {4'd0, portOut[3:0]}, 8'h05);
    readReg(8'd1, v); chk(v == 8'hA5, "R5 output reg written", v, 8'hA5);
  endtask

  task automatic t_readRepeat;
    bit a;
    logic [7:0] v;
    startC;
    sendByte(WADDR, a); sendByte(8'd1, a);
    startC; sendByte(RADDR, a);
    for (int k = 0; k < 3; k++) begin
      recvByte(k < 2, v);
      chk(v == 8'hA5, "R8 repeated read byte", v, 8'hA5);
    end
    chk(sdaLow == 1'b0, "R8 sda released after nack", {7'd0, sdaLow}, 8'd0);
    stopC;
  endtask

  task automatic t_polarity;
    logic [7:0] v;
    pins = 8'h3C;
    writeReg(8'd2, 8'h0F);
    readReg(8'd0, v); chk(v == 8'h33, "R7 input read through polarity", v, 8'h33);
    readReg(8'd2, v); chk(v == 8'h0F, "R7 polarity raw read", v, 8'h0F);
  endtask

  task automatic t_inputWrite;
    logic [7:0] v;
    writeReg(8'd0, 8'h00);
    readReg(8'd0, v); chk(v == 8'h33, "R5 input reg write ignored", v, 8'h33);
    readReg(8'd1, v); chk(v == 8'hA5, "R5 output reg unaffected", v, 8'hA5);
  endtask

  task automatic t_interrupt;
    logic [7:0] v;
    pins = 8'h3D; repeat (6) @(negedge clk);
    chk(intN == 1'b1, "R9 output pin change no interrupt", {7'd0, intN}, 8'd1);
    pins = 8'h7C; repeat (6) @(negedge clk);
    chk(intN == 1'b0, "R9 input change asserts", {7'd0, intN}, 8'd0);
    pins = 8'h3C; repeat (6) @(negedge clk);
    chk(intN == 1'b1, "R9 clears on return", {7'd0, intN}, 8'd1);
    pins = 8'h7C; repeat (6) @(negedge clk);
    chk(intN == 1'b0, "R9 asserts again", {7'd0, intN}, 8'd0);
    readReg(8'd0, v); chk(v == 8'h73, "R9 input read value", v, 8'h73);
    chk(intN == 1'b1, "R9 clears on input read", {7'd0, intN}, 8'd1);
  endtask

  task automatic t_strap;
    bit a;
    logic [7:0] v;
    startC;
    strap = 3'b000;
    sendByte(WADDR, a); chk(a, "R11 strap latched at start", {7'd0, a}, 8'd1);
    sendByte(8'd1, a);
    sendByte(8'h5A, a); chk(a, "R11 data ack", {7'd0, a}, 8'd1);
    stopC;
    strap = 3'b011;
    readReg(8'd1, v); chk(v == 8'h5A, "R11 write landed", v, 8'h5A);
  endtask

  task automatic t_repStart;
    bit a;
    logic [7:0] v;
    startC;
    sendByte(WADDR, a); sendByte(8'd3, a);
    startC;
    sendByte(RADDR, a); chk(a, "R12 ack after repeated start", {7'd0, a}, 8'd1);
    recvByte(1'b0, v); chk(v == 8'hF0, "R12 pointer kept", v, 8'hF0);
    stopC;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_noStart;
    t_wrongAddr;
    t_direction;
    t_readRepeat;
    t_polarity;
    t_inputWrite;
    t_interrupt;
    t_strap;
    t_repStart;
    chk(glitches == 0, "R10 sda changed while scl high", 8'(glitches), 8'd0);
    summary;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary;
    $finish;
  end
endmodule